// File: doc/BRIEF.md
# Interrupt Status Word

This block builds the read-only 32-bit status word of a bridge that sits between a host bus and a word-wide link to an attached processor. It gathers four interrupt sources into pending bits. Three of them are sticky: they latch on the rising edge of their event and are cleared by write-one-to-clear pulses. Those pulses come from a separate interrupt control register, which also supplies the four enables. The fourth source is a level from a JTAG controller, and its pending bit simply follows that level.

The word also reports the following:
- a combined interrupt, which is each pending bit gated by its own enable and then ORed;
- the link's output and input buffer flags;
- whether the bridge holds the link token;
- two external pins, each taken through a synchronizer.

The word is registered, and the combined interrupt is also driven on its own output pin. The host only reads the word, so the block has no write path.

Top module: `irq_status_word`

## Requirements
- R1: Bits 3:0 report `irq_en` one clock after it is sampled: output-buffer-empty enable in bit 0, input-buffer-full in bit 1, JTAG in bit 2, attached processor in bit 3.
- R2: Bit 4 (output-buffer-empty pending) sets on a rising edge of `obuf_empty`. It clears on `clr_w1c[0]`. After a clear it stays 0 while `obuf_empty` stays high.
- R3: Bit 5 (input-buffer-full pending) sets on a rising edge of `word_rx` and clears on `clr_w1c[1]`.
- R4: Bit 6 (JTAG pending) follows the synchronized `jtag_irq_pin` level. `clr_w1c[2]` has no effect on it.
- R5: Bit 7 (attached-processor pending) sets on a rising edge of the synchronized `proc_hint_pin` and clears on `clr_w1c[3]`.
- R6: If a set event and a clear pulse for a sticky pending bit arrive in the same cycle, the bit ends up set.
- R7: Bit 8 and `irq_out` both equal the OR over bits 7:4, each ANDed with the matching enable in bits 3:0.
- R8: Bit 16 sets on `oreg_load` and clears on `oreg_sent`. When both arrive in the same cycle, the bit is set.
- R9: Bit 17 sets on `word_rx` and clears on `ibuf_take`, with set taking priority. Bit 18 reports `token_own`.
- R10: Bit 20 is the inverse of `rdy_n_pin` and bit 21 is the level of `cfg_n_pin`. Each pin passes through a two-flop synchronizer first.
- R11: Bits 31:22, bit 19 and bits 15:9 always read 0.
- R12: After reset, all pending and buffer bits are 0. With enables at 0 and both pins high, the word reads 0x0020_0000.
- R13: The word is registered. A sticky or buffer event from the datapath shows two clock edges after it is sampled, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_en | input | 4 | Enables from the interrupt control register |
| clr_w1c | input | 4 | Write-one-to-clear pulses from the control register |
| obuf_empty | input | 1 | Link output buffer empty level |
| word_rx | input | 1 | Pulse: word received from the attached processor |
| ibuf_take | input | 1 | Pulse: received word consumed by the host |
| oreg_load | input | 1 | Pulse: word loaded into the link output register |
| oreg_sent | input | 1 | Pulse: output word transmitted |
| token_own | input | 1 | Bridge currently owns the link token |
| jtag_irq_pin | input | 1 | JTAG controller interrupt line (asynchronous) |
| proc_hint_pin | input | 1 | Attached processor host-interrupt flag (asynchronous) |
| rdy_n_pin | input | 1 | JTAG controller ready, active low (asynchronous) |
| cfg_n_pin | input | 1 | Configuration pin, active low (asynchronous) |
| stat_word | output | 32 | Registered status word |
| irq_out | output | 1 | Combined enabled interrupt |

## Verification
The aggregation is swept over all 16 pending patterns. For each pattern every one of the 16 enable values is applied, which shows whether each pending bit is gated by its own enable and not by a neighbour's. The pending patterns themselves come from real source events, so the sweep also shows that each source lands in its own bit and that the level-following JTAG bit behaves differently from the sticky ones.

Directed sequences separate edge capture from level capture: a clear arrives while the source stays high. They also cover the collision of a set and a clear in the same cycle, the priority in the buffer flags, the pin inversion, and the exact one-edge versus two-edge visibility of an event.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int WORD_W   = 32;
  localparam int N_SRC    = 4;
  localparam int EN_LSB   = 0;
  localparam int PEND_LSB = EN_LSB + N_SRC;
  localparam int IRQ_BIT  = PEND_LSB + N_SRC;
  localparam int OBF_BIT  = 16;
  localparam int IBF_BIT  = 17;
  localparam int TOK_BIT  = 18;
  localparam int RDY_BIT  = 20;
  localparam int CFG_BIT  = 21;
  // source index order within enables / pending / clear vectors
  localparam int SRC_OBE  = 0;
  localparam int SRC_IBF  = 1;
  localparam int SRC_JTAG = 2;
  localparam int SRC_PROC = 3;
  // 1 = sticky (edge set, write-one clear), 0 = follows level
  localparam logic [N_SRC-1:0] STICKY_MASK = 4'b1011;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/pend_cell.sv
module pend_cell #(
  parameter bit STICKY = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr,
  output logic pend
);
  logic pend_q;

  generate
    if (STICKY) begin : g_sticky
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          prev_q <= evt;
          // a new edge beats a same-cycle clear
          pend_q <= (evt & ~prev_q) | (pend_q & ~clr);
        end
      end
    end else begin : g_level
      logic unused_clr;
      assign unused_clr = clr;
      always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= evt;
      end
    end
  endgenerate

  assign pend = pend_q;
endmodule

// File: rtl/buf_flags.sv
module buf_flags #(
  parameter int N_FLAG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_FLAG-1:0] set_i,
  input  logic [N_FLAG-1:0] clr_i,
  output logic [N_FLAG-1:0] flag_o
);
  logic [N_FLAG-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_status_word.sv
module irq_status_word
  import irq_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_en,
  input  logic [N_SRC-1:0]  clr_w1c,
  input  logic              obuf_empty,
  input  logic              word_rx,
  input  logic              ibuf_take,
  input  logic              oreg_load,
  input  logic              oreg_sent,
  input  logic              token_own,
  input  logic              jtag_irq_pin,
  input  logic              proc_hint_pin,
  input  logic              rdy_n_pin,
  input  logic              cfg_n_pin,
  output logic [WORD_W-1:0] stat_word,
  output logic              irq_out
);
  localparam int N_PIN = 4;
  // pin order: jtag, proc, rdy_n, cfg_n ; idle levels high for the active-low pins
  localparam logic [N_PIN-1:0] PIN_IDLE = 4'b1100;

  logic [N_PIN-1:0]  pin_s;
  logic [N_SRC-1:0]  evt;
  logic [N_SRC-1:0]  pend;
  logic [1:0]        bflag;
  logic [WORD_W-1:0] nxt_word;
  logic [WORD_W-1:0] word_q;

  pin_sync #(.W(N_PIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({cfg_n_pin, rdy_n_pin, proc_hint_pin, jtag_irq_pin}),
    .dout (pin_s)
  );

  always_comb begin
    evt           = '0;
    evt[SRC_OBE]  = obuf_empty;
    evt[SRC_IBF]  = word_rx;
    evt[SRC_JTAG] = pin_s[0];
    evt[SRC_PROC] = pin_s[1];
  end

  generate
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      pend_cell #(.STICKY(STICKY_MASK[s])) u_pend (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt[s]),
        .clr  (clr_w1c[s]),
        .pend (pend[s])
      );
    end
  endgenerate

  buf_flags #(.N_FLAG(2)) u_bufs (
    .clk    (clk),
    .rst    (rst),
    .set_i  ({word_rx, oreg_load}),
    .clr_i  ({ibuf_take, oreg_sent}),
    .flag_o (bflag)
  );

  always_comb begin
    nxt_word = '0;
    nxt_word[EN_LSB +: N_SRC]   = irq_en;
    nxt_word[PEND_LSB +: N_SRC] = pend;
    nxt_word[IRQ_BIT]           = |(pend & irq_en);
    nxt_word[OBF_BIT]           = bflag[0];
    nxt_word[IBF_BIT]           = bflag[1];
    nxt_word[TOK_BIT]           = token_own;
    nxt_word[RDY_BIT]           = ~pin_s[2];
    nxt_word[CFG_BIT]           = pin_s[3];
  end

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= nxt_word;
  end

  assign stat_word = word_q;
  assign irq_out   = word_q[IRQ_BIT];
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  irq_en,
  input logic [3:0]  clr_w1c,
  input logic        obuf_empty,
  input logic        word_rx,
  input logic        oreg_load,
  input logic        oreg_sent,
  input logic        token_own,
  input logic        jtag_irq_pin,
  input logic        rdy_n_pin,
  input logic        cfg_n_pin,
  input logic [31:0] stat_word,
  input logic        irq_out
);
  logic [2:0] warm;
  always_ff @(posedge clk) begin
    if (rst)            warm <= '0;
    else if (warm != 3'd5) warm <= warm + 3'd1;
  end
  logic cold;
  assign cold = (warm != 3'd5);

  AST_EN_MIRROR: assert property (@(posedge clk) disable iff (rst || cold)
    stat_word[3:0] == $past(irq_en)); // R1
  AST_OBE_CLEAR: assert property (@(posedge clk) disable iff (rst || cold)
    (clr_w1c[0] && !$rose(obuf_empty)) |=> ##1 !stat_word[4]); // R2
  AST_IBF_CLEAR: assert property (@(posedge clk) disable iff (rst || cold)
    (clr_w1c[1] && !$rose(word_rx)) |=> ##1 !stat_word[5]); // R3
  AST_JTAG_FOLLOW: assert property (@(posedge clk) disable iff (rst || cold)
    stat_word[6] == $past(jtag_irq_pin, 4)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst || cold)
    $rose(obuf_empty) |=> ##1 stat_word[4]); // R6
  AST_IRQ_AGG: assert property (@(posedge clk) disable iff (rst || cold)
    irq_out == |(stat_word[7:4] & stat_word[3:0])); // R7
  AST_OBF_LOAD: assert property (@(posedge clk) disable iff (rst || cold)
    oreg_load |=> ##1 stat_word[16]); // R8
  AST_OBF_SENT: assert property (@(posedge clk) disable iff (rst || cold)
    (oreg_sent && !oreg_load) |=> ##1 !stat_word[16]); // R8
  AST_TOKEN: assert property (@(posedge clk) disable iff (rst || cold)
    stat_word[18] == $past(token_own)); // R9
  AST_PIN_RDY: assert property (@(posedge clk) disable iff (rst || cold)
    stat_word[20] == !$past(rdy_n_pin, 3)); // R10
  AST_PIN_CFG: assert property (@(posedge clk) disable iff (rst || cold)
    stat_word[21] == $past(cfg_n_pin, 3)); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (stat_word[31:22] == '0) && !stat_word[19] && (stat_word[15:9] == '0)); // R11
endmodule

bind irq_status_word irq_status_chk i_chk (.*);

// File: tb/test_irq_status_word.sv
module test_irq_status_word;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  irq_en = '0, clr_w1c = '0;
  logic        obuf_empty = 0, word_rx = 0, ibuf_take = 0, oreg_load = 0, oreg_sent = 0;
  logic        token_own = 0, jtag_irq_pin = 0, proc_hint_pin = 0, rdy_n_pin = 1, cfg_n_pin = 1;
  logic [31:0] stat_word;
  logic        irq_out;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_status_word i_irq_status_word (.*);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    tick(4); rst = 1'b0; tick(6);
    chk("R12 reset word", stat_word, 32'h0020_0000);
    chk("R12 reset irq", {31'd0, irq_out}, 32'd0);

    // R13: buffer event visible after two edges, not one
    oreg_load = 1; tick(1); oreg_load = 0;
    chk("R13 one edge", {31'd0, stat_word[16]}, 32'd0);
    tick(1);
    chk("R13 two edges", {31'd0, stat_word[16]}, 32'd1);
    oreg_sent = 1; tick(1); oreg_sent = 0; tick(2);
    chk("R8 sent clears", {31'd0, stat_word[16]}, 32'd0);
    oreg_load = 1; oreg_sent = 1; tick(1); oreg_load = 0; oreg_sent = 0; tick(2);
    chk("R8 load wins", {31'd0, stat_word[16]}, 32'd1);

    // R9 input buffer flag and token
    word_rx = 1; ibuf_take = 1; tick(1); word_rx = 0; ibuf_take = 0; tick(2);
    chk("R9 rx wins", {31'd0, stat_word[17]}, 32'd1);
    ibuf_take = 1; tick(1); ibuf_take = 0; tick(2);
    chk("R9 take clears", {31'd0, stat_word[17]}, 32'd0);
    token_own = 1; tick(2);
    chk("R9 token", {31'd0, stat_word[18]}, 32'd1);
    token_own = 0;

    // R10 pins
    rdy_n_pin = 0; cfg_n_pin = 0; tick(5);
    chk("R10 pins low", {30'd0, stat_word[21:20]}, 32'b01);
    rdy_n_pin = 1; cfg_n_pin = 1; tick(5);
    chk("R10 pins high", {30'd0, stat_word[21:20]}, 32'b10);

    // R2 edge capture: clear while level held high
    clr_w1c = 4'hF; tick(1); clr_w1c = 0; tick(2);
    obuf_empty = 1; tick(3);
    chk("R2 set", {31'd0, stat_word[4]}, 32'd1);
    clr_w1c[0] = 1; tick(1); clr_w1c = 0; tick(3);
    chk("R2 held high stays clear", {31'd0, stat_word[4]}, 32'd0);
    obuf_empty = 0; tick(2);
    // R6 set and clear together
    obuf_empty = 1; clr_w1c[0] = 1; tick(1); clr_w1c = 0; tick(3);
    chk("R6 obe set wins", {31'd0, stat_word[4]}, 32'd1);
    word_rx = 1; clr_w1c[1] = 1; tick(1); word_rx = 0; clr_w1c = 0; tick(3);
    chk("R6 ibf set wins", {31'd0, stat_word[5]}, 32'd1);
    clr_w1c[1] = 1; tick(1); clr_w1c = 0; tick(3);
    chk("R3 clear", {31'd0, stat_word[5]}, 32'd0);

    // R4 level follow, clear ignored
    jtag_irq_pin = 1; tick(6);
    chk("R4 follows high", {31'd0, stat_word[6]}, 32'd1);
    clr_w1c[2] = 1; tick(1); clr_w1c = 0; tick(3);
    chk("R4 clear ignored", {31'd0, stat_word[6]}, 32'd1);
    jtag_irq_pin = 0; tick(6);
    chk("R4 follows low", {31'd0, stat_word[6]}, 32'd0);

    // R5 processor flag, clear while held
    proc_hint_pin = 1; tick(6);
    chk("R5 set", {31'd0, stat_word[7]}, 32'd1);
    clr_w1c[3] = 1; tick(1); clr_w1c = 0; tick(4);
    chk("R5 clear", {31'd0, stat_word[7]}, 32'd0);
    proc_hint_pin = 0; tick(6);

    // R1 R7 R11: sweep all pending patterns x all enables
    for (int p = 0; p < 16; p++) begin
      obuf_empty = 0; word_rx = 0; jtag_irq_pin = 0; proc_hint_pin = 0; tick(6);
      clr_w1c = 4'hF; tick(1); clr_w1c = 0; tick(2);
      obuf_empty = p[0]; jtag_irq_pin = p[2]; proc_hint_pin = p[3]; word_rx = p[1];
      tick(1); word_rx = 0; tick(6);
      for (int e = 0; e < 16; e++) begin
        logic [3:0] pv, ev;
        logic       ex;
        pv = p[3:0]; ev = e[3:0];
        ex = (pv[0] & ev[0]) | (pv[1] & ev[1]) | (pv[2] & ev[2]) | (pv[3] & ev[3]);
        irq_en = ev; tick(2);
        chk("R1 R7 word[8:0]", {23'd0, stat_word[8:0]}, {23'd0, ex, pv, ev});
        chk("R7 irq_out", {31'd0, irq_out}, {31'd0, ex});
        chk("R11 reserved", stat_word & 32'hFFC8_FE00, 32'd0);
      end
      ibuf_take = 1; tick(1); ibuf_take = 0;
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule